// File: doc/BRIEF.md
# Bus Master Activity Detector

This block gathers activity indications from every bus-mastering agent in the chipset into a single sticky flag. Power management logic reads the flag to decide whether the processor may stay in, or must leave, its deepest idle state. An agent counts as active when it is requesting or running transfers. The flag stays set until software clears it, so a short burst of activity is never missed between two polls.

The sources are the PCI request lines, an internal bus-master request, an active-low graphics-busy line, three USB host controllers, a disk DMA engine start bit and four audio DMA run bits. A USB controller counts as busy only when three things are true at once: it is running, it is not in global suspend, and at least one of its ports is awake. The flag is cleared by writing a one to it through a one-bit write port. The flag drives no interrupt, system management event or wake event. All inputs are assumed to be synchronous to `clk` already.

Top module: `busact_detect`

## Requirements
- R1: A synchronous active-high `rst` forces `activity_seen` to 0 on the next clock edge, even when sources are active.
- R2: When any bit of `pci_req` is 1, `activity_seen` is 1 after the next clock edge.
- R3: When `int_req` is 1, `activity_seen` is 1 after the next clock edge.
- R4: When `gfx_busy_n` is 0, `activity_seen` is 1 after the next clock edge. A value of 1 on `gfx_busy_n` sets nothing.
- R5: USB controller c (c = 0..2) sets `activity_seen` after the next edge only when `usb_run[c]`=1, `usb_gsusp[c]`=0 and the two bits `usb_port_susp[2c+1:2c]` are not both 1. Any other combination sets nothing.
- R6: When `disk_start` is 1, `activity_seen` is 1 after the next clock edge.
- R7: When any bit of `aud_run` is 1, `activity_seen` is 1 after the next clock edge. The bits are bit 0 PCM in, bit 1 PCM out, bit 2 microphone and bit 3 modem.
- R8: Once set, `activity_seen` stays 1 while no clearing write occurs.
- R9: A cycle with `clr_wr_en`=1 and `clr_wr_data`=1 and no active source makes `activity_seen` 0 after that edge. A write with `clr_wr_data`=0 has no effect.
- R10: If a source is active in the same cycle as a clearing write, `activity_seen` is 1 after that edge.
- R11: With no active source and no write, a cleared `activity_seen` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pci_req | input | 4 | PCI bus request lines, 1 = requesting |
| int_req | input | 1 | Internal bus-master request |
| gfx_busy_n | input | 1 | Graphics busy, active low |
| usb_run | input | 3 | Run bit of each USB controller |
| usb_gsusp | input | 3 | Global-suspend state of each USB controller |
| usb_port_susp | input | 6 | Port suspend bits, two per controller |
| disk_start | input | 1 | Disk DMA engine start bit |
| aud_run | input | 4 | Audio DMA run bits |
| clr_wr_en | input | 1 | Write strobe for the status flag |
| clr_wr_data | input | 1 | Write data, 1 clears the flag |
| activity_seen | output | 1 | Sticky bus-master activity flag |

## Verification
The USB term is the hardest case to reach from the ports. It fires only when run, not-global-suspend and port-awake hold together, and a single wrong combination can hide behind any other active source. The bench therefore sweeps all sixteen combinations of run, global suspend and the two port bits for each controller on its own, with every other source idle, and clears the flag before and after each case. The set-versus-clear race is reached by holding a source active in the same cycle as the clearing write.

// File: rtl/busact_pkg.sv
package busact_pkg;
    localparam int PCI_LINES  = 4;
    localparam int USB_CTRLS  = 3;
    localparam int USB_PORTS  = 2;
    localparam int AUD_ENGINES = 4;

    typedef struct packed {
        logic pci;
        logic intr;
        logic gfx;
        logic usb;
        logic disk;
        logic aud;
    } act_terms_t;

    function automatic logic any_term(input act_terms_t t);
        return t.pci | t.intr | t.gfx | t.usb | t.disk | t.aud;
    endfunction
endpackage

// File: rtl/busact_usb_term.sv
module busact_usb_term
    import busact_pkg::*;
#(
    parameter int NPORT = USB_PORTS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             gsusp,
    input  logic [NPORT-1:0] port_susp,
    output logic             busy
);
    logic port_awake;

    always_comb begin
        port_awake = ~(&port_susp);
        busy       = run & ~gsusp & port_awake;
    end

    a_r5_gsusp_blocks: assert property (@(posedge clk) disable iff (rst)
        gsusp |-> !busy);
    a_r5_halted_blocks: assert property (@(posedge clk) disable iff (rst)
        !run |-> !busy);
endmodule

// File: rtl/busact_merge.sv
module busact_merge
    import busact_pkg::*;
#(
    parameter int NPCI = PCI_LINES,
    parameter int NUSB = USB_CTRLS,
    parameter int NAUD = AUD_ENGINES
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPCI-1:0] pci_req,
    input  logic            int_req,
    input  logic            gfx_busy_n,
    input  logic [NUSB-1:0] usb_busy,
    input  logic            disk_start,
    input  logic [NAUD-1:0] aud_run,
    output act_terms_t      terms,
    output logic            any_active
);
    always_comb begin
        terms.pci  = |pci_req;
        terms.intr = int_req;
        terms.gfx  = ~gfx_busy_n;
        terms.usb  = |usb_busy;
        terms.disk = disk_start;
        terms.aud  = |aud_run;
        any_active = any_term(terms);
    end

    a_r4_gfx_low_active: assert property (@(posedge clk) disable iff (rst)
        !gfx_busy_n |-> any_active);
    a_r7_audio_active: assert property (@(posedge clk) disable iff (rst)
        (aud_run != '0) |-> any_active);
    a_r2_pci_active: assert property (@(posedge clk) disable iff (rst)
        (pci_req != '0) |-> any_active);
endmodule

// File: rtl/busact_sticky.sv
module busact_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else
            flag_o <= set_i | (flag_o & ~clr_i);
    end

    a_r8_holds: assert property (@(posedge clk) disable iff (rst)
        flag_o && !clr_i |=> flag_o);
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        clr_i && !set_i |=> !flag_o);
    a_r11_stays_low: assert property (@(posedge clk) disable iff (rst)
        !flag_o && !set_i |=> !flag_o);
endmodule

// File: rtl/busact_detect.sv
module busact_detect
    import busact_pkg::*;
#(
    parameter int NPCI  = PCI_LINES,
    parameter int NUSB  = USB_CTRLS,
    parameter int NPORT = USB_PORTS,
    parameter int NAUD  = AUD_ENGINES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NPCI-1:0]       pci_req,
    input  logic                  int_req,
    input  logic                  gfx_busy_n,
    input  logic [NUSB-1:0]       usb_run,
    input  logic [NUSB-1:0]       usb_gsusp,
    input  logic [NUSB*NPORT-1:0] usb_port_susp,
    input  logic                  disk_start,
    input  logic [NAUD-1:0]       aud_run,
    input  logic                  clr_wr_en,
    input  logic                  clr_wr_data,
    output logic                  activity_seen
);
    logic [NUSB-1:0] usb_busy;
    act_terms_t      terms;
    logic            any_active;
    logic            clr_hit;

    for (genvar g = 0; g < NUSB; g++) begin : g_usb
        busact_usb_term #(.NPORT(NPORT)) u_term (
            .clk       (clk),
            .rst       (rst),
            .run       (usb_run[g]),
            .gsusp     (usb_gsusp[g]),
            .port_susp (usb_port_susp[g*NPORT +: NPORT]),
            .busy      (usb_busy[g])
        );
    end

    busact_merge #(.NPCI(NPCI), .NUSB(NUSB), .NAUD(NAUD)) u_merge (
        .clk        (clk),
        .rst        (rst),
        .pci_req    (pci_req),
        .int_req    (int_req),
        .gfx_busy_n (gfx_busy_n),
        .usb_busy   (usb_busy),
        .disk_start (disk_start),
        .aud_run    (aud_run),
        .terms      (terms),
        .any_active (any_active)
    );

    assign clr_hit = clr_wr_en & clr_wr_data;

    busact_sticky u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (any_active),
        .clr_i  (clr_hit),
        .flag_o (activity_seen)
    );

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> !activity_seen);
    a_r3_int_sets: assert property (@(posedge clk) disable iff (rst)
        int_req |=> activity_seen);
    a_r6_disk_sets: assert property (@(posedge clk) disable iff (rst)
        disk_start |=> activity_seen);
endmodule

// File: tb/busact_detect_tb.sv
module busact_detect_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] pci_req;
    logic       int_req;
    logic       gfx_busy_n;
    logic [2:0] usb_run;
    logic [2:0] usb_gsusp;
    logic [5:0] usb_port_susp;
    logic       disk_start;
    logic [3:0] aud_run;
    logic       clr_wr_en;
    logic       clr_wr_data;
    logic       activity_seen;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    busact_detect u_dut (
        .clk           (clk),
        .rst           (rst),
        .pci_req       (pci_req),
        .int_req       (int_req),
        .gfx_busy_n    (gfx_busy_n),
        .usb_run       (usb_run),
        .usb_gsusp     (usb_gsusp),
        .usb_port_susp (usb_port_susp),
        .disk_start    (disk_start),
        .aud_run       (aud_run),
        .clr_wr_en     (clr_wr_en),
        .clr_wr_data   (clr_wr_data),
        .activity_seen (activity_seen)
    );

    task automatic idle();
        pci_req       = '0;
        int_req       = 1'b0;
        gfx_busy_n    = 1'b1;
        usb_run       = '0;
        usb_gsusp     = '0;
        usb_port_susp = '0;
        disk_start    = 1'b0;
        aud_run       = '0;
        clr_wr_en     = 1'b0;
        clr_wr_data   = 1'b0;
    endtask

    // One edge passes, then the output is sampled at the falling edge.
    task automatic step_check(input logic exp, input string req);
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (activity_seen !== exp) begin
            failures++;
            $display("FAIL %s: activity_seen=%b expected=%b", req, activity_seen, exp);
        end
    endtask

    task automatic clear_flag(input string req);
        idle();
        clr_wr_en   = 1'b1;
        clr_wr_data = 1'b1;
        step_check(1'b0, req);
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        idle();
        rst = 1'b1;
        @(negedge clk);
        step_check(1'b0, "R1");
        rst = 1'b0;
        step_check(1'b0, "R11");

        // R2: each PCI request line alone
        for (int i = 0; i < 4; i++) begin
            idle();
            pci_req[i] = 1'b1;
            step_check(1'b1, "R2");
            clear_flag("R9");
        end

        // R3
        idle(); int_req = 1'b1;
        step_check(1'b1, "R3");
        clear_flag("R9");

        // R4: high level of gfx_busy_n sets nothing, low level sets
        idle();
        step_check(1'b0, "R4");
        gfx_busy_n = 1'b0;
        step_check(1'b1, "R4");
        clear_flag("R9");

        // R5: every combination of run, global suspend and port bits
        for (int c = 0; c < 3; c++) begin
            for (int v = 0; v < 16; v++) begin
                logic run_b, gs_b, exp_b;
                logic [1:0] ps;
                run_b = v[0];
                gs_b  = v[1];
                ps    = 2'(v >> 2);
                exp_b = run_b & ~gs_b & (ps != 2'b11);
                idle();
                usb_run[c]           = run_b;
                usb_gsusp[c]         = gs_b;
                usb_port_susp[c*2+:2] = ps;
                step_check(exp_b, "R5");
                clear_flag("R9");
            end
        end

        // R6
        idle(); disk_start = 1'b1;
        step_check(1'b1, "R6");
        clear_flag("R9");

        // R7: all sixteen audio run patterns
        for (int v = 0; v < 16; v++) begin
            idle();
            aud_run = 4'(v);
            step_check(v != 0, "R7");
            clear_flag("R9");
        end

        // R8: flag holds with sources idle
        idle(); int_req = 1'b1;
        step_check(1'b1, "R8");
        idle();
        step_check(1'b1, "R8");
        step_check(1'b1, "R8");

        // R9: write of zero does nothing
        clr_wr_en = 1'b1; clr_wr_data = 1'b0;
        step_check(1'b1, "R9");
        // R10: set wins over a clearing write
        idle(); aud_run = 4'b0100; clr_wr_en = 1'b1; clr_wr_data = 1'b1;
        step_check(1'b1, "R10");
        idle(); pci_req = 4'b1000; clr_wr_en = 1'b1; clr_wr_data = 1'b1;
        step_check(1'b1, "R10");
        clear_flag("R9");

        // R11: cleared flag stays low when nothing happens
        idle();
        step_check(1'b0, "R11");
        step_check(1'b0, "R11");

        // R1: reset beats active sources
        idle(); disk_start = 1'b1; int_req = 1'b1;
        step_check(1'b1, "R6");
        rst = 1'b1;
        step_check(1'b0, "R1");
        rst = 1'b0;
        idle();
        step_check(1'b0, "R11");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule